// File: doc/BRIEF.md
# Super I/O Configuration Register File

This block is the configuration space of a legacy multi-function I/O controller. The host sees two byte-wide ports: an index port and a data port. The block ignores all configuration traffic until the host writes an unlock key to the index port. Once unlocked, the host writes a register number to the index port. It then reads or writes that register through the data port. A lock key written to the index port closes the window again.

Register numbers below 0x30 form one global bank that every logical device shares. Global register 7 names the active logical device. Register numbers from 0x30 up reach a private bank that belongs to the active device. There are up to 16 such banks. The active device number is also driven out so that logic downstream can decode which function the host is setting up.

Top module: `sio_cfg_regfile`

## Requirements
- R1: After reset, configuration mode is off, the index is 0, the selected device is 0, every register reads 0, except global register 0x26, which reads 0x2E.
- R2: While configuration mode is off, no write changes the index, any register or the selected device, except the unlock write of R4.
- R3: While configuration mode is off, a read strobe on either port returns 0.
- R4: Writing 0x55 to the index port (port_sel = 0) while configuration mode is off turns configuration mode on.
- R5: Writing 0xAA to the index port while configuration mode is on turns it off. The index keeps its previous value, and that value is read back after the next unlock.
- R6: In configuration mode, any other value written to the index port, including 0x55, loads the index. A read of the index port (port_sel = 0) returns the current index.
- R7: In configuration mode, with an index below 0x30, data-port (port_sel = 1) reads and writes reach the shared global register of that number.
- R8: The selected device (dev_sel) changes only on a data-port write to a global register. Such a write reloads it from global register 7, using the new value when register 7 is the one written.
- R9: In configuration mode, with an index of 0x30 or above, data-port reads and writes reach the register of that number in the selected device's own bank. Banks of different devices are independent.
- R10: Only the low 4 bits of global register 7 pick the device, so a value of 0x13 selects device 3. The register itself still reads back all 8 bits.
- R11: A device-bank register reads 0 until it has been written after reset.
- R12: While rd_en is low, rd_data is 0. Read data is combinational from the current port, index and bank. A write takes effect at the clock edge where wr_en is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_en | input | 1 | Read strobe; enables rd_data |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte (combinational) |
| dev_sel | output | 4 | Active logical device number |

## Verification
The hardest case to reach from the ports is a device bank whose contents must stay apart from the other banks. The stimulus reaches it by writing register 7, then writing a banked index, then switching devices and reading the same index back, both before and after any write to the second bank. Two corner cases also need a planned sequence: a device value above 15 that wraps into the banks, and an index value that survives a lock and unlock cycle. For the second, the bench locks the block with a known index, sends ignored index and data writes while locked, and only then unlocks and reads the index and the register back.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] KEY_ENTER = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_EXIT  = 8'hAA;

  localparam logic PORT_INDEX = 1'b0;
  localparam logic PORT_DATA  = 1'b1;

  // decoded write intent for one host cycle
  typedef struct packed {
    logic idx_wr;
    logic glob_wr;
    logic bank_wr;
  } sio_wr_t;
endpackage

// File: rtl/sio_key_ctrl.sv
module sio_key_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              cfg_on,
  output logic [IDX_W-1:0]  cfg_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_on  <= 1'b0;
      cfg_idx <= '0;
    end else if (idx_wr) begin
      if (!cfg_on) begin
        if (wr_data == KEY_ENTER) cfg_on <= 1'b1;
      end else if (wr_data == KEY_EXIT) begin
        cfg_on <= 1'b0;
      end else begin
        cfg_idx <= wr_data[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sio_global_bank.sv
module sio_global_bank
  import sio_cfg_pkg::*;
#(
  parameter int              GLOBAL_COUNT = 48,
  parameter int              IDX_W        = 8,
  parameter int              DEV_W        = 4,
  parameter int              DEVSEL_IDX   = 7,
  parameter int              RESET_IDX    = 'h26,
  parameter logic [BYTE_W-1:0] RESET_VAL  = 8'h2E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_val,
  output logic [DEV_W-1:0]  dev_sel
);
  localparam int GSEL_W = $clog2(GLOBAL_COUNT);

  logic [BYTE_W-1:0] regs [GLOBAL_COUNT];
  logic [GSEL_W-1:0] gsel;
  logic              in_glob;

  assign gsel    = idx[GSEL_W-1:0];
  assign in_glob = idx < IDX_W'(GLOBAL_COUNT);

  for (genvar g = 0; g < GLOBAL_COUNT; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] INIT = (g == RESET_IDX) ? RESET_VAL : '0;
    always_ff @(posedge clk) begin
      if (rst)                                   regs[g] <= INIT;
      else if (wr_en && idx == IDX_W'(g))        regs[g] <= wr_data;
    end
  end

  assign rd_val = in_glob ? regs[gsel] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_sel <= '0;
    end else if (wr_en) begin
      dev_sel <= (idx == IDX_W'(DEVSEL_IDX)) ? wr_data[DEV_W-1:0]
                                             : regs[DEVSEL_IDX][DEV_W-1:0];
    end
  end
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV      = 16,
  parameter int REG_COUNT    = 256,
  parameter int GLOBAL_COUNT = 48,
  parameter int IDX_W        = 8,
  parameter int DEV_W        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DEV_W-1:0]  dev,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_val
);
  localparam int BANK_WORDS = REG_COUNT - GLOBAL_COUNT;
  localparam int DEPTH      = NUM_DEV * BANK_WORDS;
  localparam int ADDR_W     = $clog2(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  offs;
  logic              in_bank;

  assign offs    = idx - IDX_W'(GLOBAL_COUNT);
  assign in_bank = idx >= IDX_W'(GLOBAL_COUNT);
  assign addr    = ADDR_W'(dev) * ADDR_W'(BANK_WORDS) + ADDR_W'(offs);

  // data array: no reset, so it can map onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end

  // one flag per entry supplies the zero reset state
  always_ff @(posedge clk) begin
    if (rst)        written       <= '0;
    else if (wr_en) written[addr] <= 1'b1;
  end

  assign rd_val = (in_bank && written[addr]) ? mem[addr] : '0;
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
#(
  parameter int              NUM_DEV      = 16,
  parameter int              REG_COUNT    = 256,
  parameter int              GLOBAL_COUNT = 48,
  parameter int              DEVSEL_IDX   = 7,
  parameter int              RESET_IDX    = 'h26,
  parameter logic [7:0]      RESET_VAL    = 8'h2E
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       port_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [$clog2(NUM_DEV)-1:0] dev_sel
);
  localparam int IDX_W = $clog2(REG_COUNT);
  localparam int DEV_W = $clog2(NUM_DEV);

  logic              cfg_on;
  logic [IDX_W-1:0]  cfg_idx;
  logic              is_glob;
  sio_wr_t           wr;
  logic [BYTE_W-1:0] glob_rd;
  logic [BYTE_W-1:0] bank_rd;

  assign is_glob    = cfg_idx < IDX_W'(GLOBAL_COUNT);
  assign wr.idx_wr  = wr_en && (port_sel == PORT_INDEX);
  assign wr.glob_wr = wr_en && (port_sel == PORT_DATA) && cfg_on && is_glob;
  assign wr.bank_wr = wr_en && (port_sel == PORT_DATA) && cfg_on && !is_glob;

  sio_key_ctrl #(.IDX_W(IDX_W)) u_key (
    .clk     (clk),
    .rst     (rst),
    .idx_wr  (wr.idx_wr),
    .wr_data (wr_data),
    .cfg_on  (cfg_on),
    .cfg_idx (cfg_idx)
  );

  sio_global_bank #(
    .GLOBAL_COUNT (GLOBAL_COUNT),
    .IDX_W        (IDX_W),
    .DEV_W        (DEV_W),
    .DEVSEL_IDX   (DEVSEL_IDX),
    .RESET_IDX    (RESET_IDX),
    .RESET_VAL    (RESET_VAL)
  ) u_glob (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr.glob_wr),
    .idx     (cfg_idx),
    .wr_data (wr_data),
    .rd_val  (glob_rd),
    .dev_sel (dev_sel)
  );

  sio_dev_bank #(
    .NUM_DEV      (NUM_DEV),
    .REG_COUNT    (REG_COUNT),
    .GLOBAL_COUNT (GLOBAL_COUNT),
    .IDX_W        (IDX_W),
    .DEV_W        (DEV_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr.bank_wr),
    .dev     (dev_sel),
    .idx     (cfg_idx),
    .wr_data (wr_data),
    .rd_val  (bank_rd)
  );

  always_comb begin
    if (!rd_en || !cfg_on)          rd_data = '0;
    else if (port_sel == PORT_INDEX) rd_data = BYTE_W'(cfg_idx);
    else if (is_glob)               rd_data = glob_rd;
    else                            rd_data = bank_rd;
  end
endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker #(
  parameter int IDX_W        = 8,
  parameter int DEV_W        = 4,
  parameter int GLOBAL_COUNT = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             port_sel,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       rd_data,
  input logic [DEV_W-1:0] dev_sel,
  input logic             cfg_on,
  input logic [IDX_W-1:0] cfg_idx
);
  p_locked_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_on && wr_en && !(!port_sel && wr_data == 8'h55))
      |=> (!cfg_on && $stable(cfg_idx) && $stable(dev_sel)));

  p_locked_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_on && rd_en) |-> (rd_data == 8'h00));

  p_unlock_key_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_on && wr_en && !port_sel && wr_data == 8'h55) |=> cfg_on);

  p_lock_key_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_on && wr_en && !port_sel && wr_data == 8'hAA)
      |=> (!cfg_on && $stable(cfg_idx)));

  p_index_load_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_on && wr_en && !port_sel && wr_data != 8'hAA)
      |=> (cfg_on && cfg_idx == $past(wr_data[IDX_W-1:0])));

  p_index_read_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_on && rd_en && !port_sel) |-> (rd_data == 8'(cfg_idx)));

  p_devsel_source_r8: assert property (@(posedge clk) disable iff (rst)
    (dev_sel != $past(dev_sel))
      |-> $past(cfg_on && wr_en && port_sel && cfg_idx < IDX_W'(GLOBAL_COUNT)));

  p_idle_read_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rd_data == 8'h00));
endmodule

bind sio_cfg_regfile sio_cfg_checker #(
  .IDX_W        (IDX_W),
  .DEV_W        (DEV_W),
  .GLOBAL_COUNT (GLOBAL_COUNT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .port_sel (port_sel),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .dev_sel  (dev_sel),
  .cfg_on   (cfg_on),
  .cfg_idx  (cfg_idx)
);

// File: tb/sim_sio_cfg_regfile.sv
module sim_sio_cfg_regfile;
  localparam int CLK_PERIOD = 10;
  localparam logic IDX = 1'b0;
  localparam logic DAT = 1'b1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       port_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] dev_sel;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_regfile u0 (
    .clk      (clk),
    .rst      (rst),
    .port_sel (port_sel),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .dev_sel  (dev_sel)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // monitor: compares every read strobe against the scoreboard
  always @(negedge clk) begin
    if (rd_en && !rst) begin
      if (sb.size() == 0) begin
        check("scoreboard underflow", rd_data, 8'hxx);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic wr(logic p, logic [7:0] d);
    @(posedge clk); #1;
    port_sel = p; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic p, logic [7:0] exp, string tag);
    item_t it;
    @(posedge clk); #1;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    port_sel = p; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic chk_dev(logic [3:0] exp, string tag);
    @(negedge clk);
    check(tag, 8'(dev_sel), 8'(exp));
  endtask

  task automatic chk_idle(logic p, string tag);
    @(posedge clk); #1;
    port_sel = p;
    @(negedge clk);
    check(tag, rd_data, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    chk_dev(4'd0, "R1 reset device");
    rd(IDX, 8'h00, "R3 locked index read");
    rd(DAT, 8'h00, "R3 locked data read");

    // locked writes that must do nothing
    wr(IDX, 8'h12);
    wr(DAT, 8'h99);
    wr(IDX, 8'hAA);
    chk_dev(4'd0, "R2 locked device");

    wr(IDX, 8'h55);
    rd(IDX, 8'h00, "R4 R1 R2 unlocked index");
    wr(IDX, 8'h26);
    rd(DAT, 8'h2E, "R1 global 0x26 reset value");
    wr(IDX, 8'h00);
    rd(DAT, 8'h00, "R2 locked data write ignored");
    wr(IDX, 8'h07);
    rd(DAT, 8'h00, "R1 device select reg reset");
    wr(IDX, 8'h55);
    rd(IDX, 8'h55, "R6 0x55 loads index when unlocked");

    // global bank
    wr(IDX, 8'h10); wr(DAT, 8'hA5);
    rd(DAT, 8'hA5, "R7 global 0x10");
    chk_dev(4'd0, "R8 other global write keeps device");
    wr(IDX, 8'h2F); wr(DAT, 8'h3C);
    rd(DAT, 8'h3C, "R7 global 0x2F boundary");

    // device banks
    wr(IDX, 8'h30);
    rd(DAT, 8'h00, "R11 dev0 0x30 unwritten");
    wr(DAT, 8'h11);
    rd(DAT, 8'h11, "R9 dev0 0x30");
    wr(IDX, 8'hFF); wr(DAT, 8'hEE);
    rd(DAT, 8'hEE, "R9 dev0 0xFF");

    wr(IDX, 8'h07); wr(DAT, 8'h03);
    chk_dev(4'd3, "R8 select device 3");
    wr(IDX, 8'h30);
    rd(DAT, 8'h00, "R11 dev3 0x30 unwritten");
    wr(DAT, 8'h33);
    rd(DAT, 8'h33, "R9 dev3 0x30");
    chk_dev(4'd3, "R8 bank write keeps device");
    wr(IDX, 8'hFF);
    rd(DAT, 8'h00, "R9 dev3 0xFF independent");

    wr(IDX, 8'h07); wr(DAT, 8'h00);
    chk_dev(4'd0, "R8 back to device 0");
    wr(IDX, 8'h30);
    rd(DAT, 8'h11, "R9 dev0 0x30 kept");

    // wrap of the device number
    wr(IDX, 8'h07); wr(DAT, 8'h13);
    chk_dev(4'd3, "R10 0x13 selects device 3");
    rd(DAT, 8'h13, "R10 register 7 full byte");
    wr(IDX, 8'h30);
    rd(DAT, 8'h33, "R10 wrapped bank");

    // idle read and lock/unlock retention
    wr(IDX, 8'h42); wr(DAT, 8'h77);
    chk_idle(DAT, "R12 no strobe gives zero");
    wr(IDX, 8'hAA);
    rd(IDX, 8'h00, "R3 relocked index read");
    rd(DAT, 8'h00, "R3 relocked data read");
    wr(DAT, 8'h01);
    wr(IDX, 8'h31);
    chk_dev(4'd3, "R2 locked device kept");
    wr(IDX, 8'h55);
    rd(IDX, 8'h42, "R5 index kept over lock");
    rd(DAT, 8'h77, "R2 locked data write ignored in bank");

    while (sb.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule